// File: doc/BRIEF.md
# Framed Serial Receiver with Page Buffering

This block sits behind a byte-level serial receiver. It collects incoming bytes into frames and keeps each frame in a receive page until the host takes it. A frame opens with three header bytes: source, destination and payload length. The payload follows, then two check bytes. The receiver supplies a byte strobe and a bus-idle strobe. Every frame starts on the first byte after the bus has been idle. The block checks the frame with a 16-bit CRC. It then either hands the page to the host or drops it, and raises sticky status bits when a frame is lost or broken.

The host reads a page one byte at a time through a read strobe. The read pointer advances on each strobe and can be rewound. A page-switch command releases the page that was read and presents the next finished page. A status word for the presented page is zero for a good frame. For a broken frame it records how many bytes arrived.

Top module: `frame_rx_pager`

## Requirements
- R1: A frame whose length byte (third byte) is at most MAX_LEN and whose CRC checks becomes readable. Its bytes come out in arrival order, CRC bytes included, starting at read position 0. The page status is 0 and rx_ready is 1.
- R2: The CRC is CRC-16 with polynomial 0x8005 in reflected form (0xA001), initial value 0xFFFF and no final XOR. The check bytes are sent low byte first, and a frame is good when the CRC taken over all its bytes is zero. A frame that fails the check sets rx_err.
- R3: A length byte above MAX_LEN breaks the frame at that byte. Later bytes up to the next idle strobe are ignored.
- R4: An idle strobe that arrives before length+5 bytes have been received breaks the frame and sets rx_err.
- R5: With cfg_keep_broken=1 a broken frame stays in its page and is presented like a good one. Its page status is then the number of bytes received (positions counted from 1). With cfg_keep_broken=0 a broken frame is dropped.
- R6: A frame whose first byte arrives while every page is full is discarded and sets rx_lost. Pages already waiting are not changed.
- R7: NPAGE pages are filled and presented in arrival order. rx_ready stays 1 while the presented page holds a frame. page_switch with rx_ready=1 releases that page and presents the next one.
- R8: rd_ptr_rst rewinds the read position of the presented page to 0.
- R9: With cfg_user_crc=1 no CRC check is made. Every complete frame is accepted with status 0, and its last two bytes can be read as data.
- R10: rx_lost and rx_err are sticky and are cleared by clr_lost and clr_err.
- R11: rx_reset empties all pages, clears both flags and abandons a frame in progress.
- R12: After a frame completes, bytes that arrive before the next idle strobe are ignored.
- R13: After rst_n, rx_ready, rx_lost, rx_err and page_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous reset of the whole receive path |
| byte_vld | input | 1 | A received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| bus_idle | input | 1 | One-cycle strobe: the line has gone idle |
| cfg_user_crc | input | 1 | Skip the CRC check |
| cfg_keep_broken | input | 1 | Keep broken frames for the host |
| clr_lost | input | 1 | Clear rx_lost |
| clr_err | input | 1 | Clear rx_err |
| host_rd | input | 1 | Advance the read position |
| rd_ptr_rst | input | 1 | Rewind the read position |
| page_switch | input | 1 | Release the presented page |
| rd_data | output | 8 | Byte at the read position of the presented page |
| page_flag | output | ADDR_W | Status of the presented page |
| rx_ready | output | 1 | A finished page is presented |
| rx_lost | output | 1 | Sticky: frame lost for lack of a page |
| rx_err | output | 1 | Sticky: broken frame seen |

## Verification
The bench sends good frames for every payload length from 0 to MAX_LEN, and sends each one again with its last byte damaged. This separates a working length count and CRC residue from an off-by-one in the end-of-frame decision. It cuts one frame short at every byte position with saving enabled, which shows that the recorded count follows the last byte written. It also sends an oversize length byte to show that the frame breaks at the length byte and not later. Frames sent back to back into full pages, bytes arriving after a frame has completed, and a receive reset in the middle of a frame check that the pages, the flags and the skip-until-idle rule hold together.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_SKIP = 2'd2
    } rx_state_e;

    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
    localparam logic [15:0] CRC_INIT      = 16'hFFFF;

    // One byte through the reflected CRC-16, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [7:0]  d);
        logic [15:0] c;
        c = c_in ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/frame_rx_crc.sv
module frame_rx_crc
    import frame_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        first,
    input  logic [7:0]  din,
    output logic [15:0] crc_next
);

    typedef struct packed {
        logic [15:0] crc;
    } crc_s;

    crc_s s_d, s_q;

    always_comb begin
        crc_next = crc16_step(first ? CRC_INIT : s_q.crc, din);
        s_d      = s_q;
        if (en) begin
            s_d.crc = crc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.crc <= CRC_INIT;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/frame_rx_ctl.sv
module frame_rx_ctl
    import frame_rx_pkg::*;
#(
    parameter int MAX_LEN = 253,
    parameter int DEPTH   = MAX_LEN + 5,
    parameter int ADDR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              bus_idle,
    input  logic              cfg_user_crc,
    input  logic              cfg_keep_broken,
    input  logic              clr_lost,
    input  logic              clr_err,
    input  logic              page_free,
    input  logic [15:0]       crc_next,
    output logic              crc_en,
    output logic              crc_first,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_flag,
    output logic              rx_lost,
    output logic              rx_err
);

    typedef struct packed {
        rx_state_e         state;
        logic [ADDR_W-1:0] cnt;
        logic [7:0]        len;
        logic              lost;
        logic              err;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{state: RX_IDLE, cnt: '0, len: '0,
                                   lost: 1'b0, err: 1'b0};

    ctl_s s_d, s_q;

    logic              set_lost;
    logic              set_err;
    logic [ADDR_W-1:0] cnt_inc;
    logic [ADDR_W-1:0] frame_total;

    // CRC control depends on state only, kept apart from the main process.
    assign crc_first = (s_q.state == RX_IDLE);
    assign crc_en    = byte_vld && (s_q.state != RX_SKIP);

    assign cnt_inc     = s_q.cnt + 1'b1;
    assign frame_total = ADDR_W'(s_q.len) + ADDR_W'(5);

    always_comb begin
        s_d         = s_q;
        wr_en       = 1'b0;
        wr_addr     = s_q.cnt;
        wr_data     = byte_data;
        commit      = 1'b0;
        commit_flag = '0;
        set_lost    = 1'b0;
        set_err     = 1'b0;

        unique case (s_q.state)
            RX_IDLE: begin
                if (byte_vld) begin
                    if (!page_free) begin
                        set_lost  = 1'b1;
                        s_d.state = RX_SKIP;
                    end else begin
                        wr_en     = 1'b1;
                        wr_addr   = '0;
                        s_d.cnt   = ADDR_W'(1);
                        s_d.state = RX_RECV;
                    end
                end
            end
            RX_RECV: begin
                if (byte_vld) begin
                    wr_en   = 1'b1;
                    s_d.cnt = cnt_inc;
                    if (s_q.cnt == ADDR_W'(2)) begin
                        s_d.len = byte_data;
                        if (int'(byte_data) > MAX_LEN) begin
                            set_err     = 1'b1;
                            commit      = cfg_keep_broken;
                            commit_flag = cfg_keep_broken ? cnt_inc : '0;
                            s_d.state   = RX_SKIP;
                        end
                    end else if (s_q.cnt > ADDR_W'(2) && cnt_inc == frame_total) begin
                        s_d.state = RX_SKIP;
                        if (cfg_user_crc || crc_next == 16'h0000) begin
                            commit = 1'b1;
                        end else begin
                            set_err     = 1'b1;
                            commit      = cfg_keep_broken;
                            commit_flag = cfg_keep_broken ? cnt_inc : '0;
                        end
                    end
                end else if (bus_idle) begin
                    set_err     = 1'b1;
                    commit      = cfg_keep_broken;
                    commit_flag = cfg_keep_broken ? s_q.cnt : '0;
                    s_d.state   = RX_IDLE;
                end
            end
            RX_SKIP: begin
                if (bus_idle) begin
                    s_d.state = RX_IDLE;
                end
            end
            default: s_d.state = RX_IDLE;
        endcase

        s_d.lost = set_lost || (s_q.lost && !clr_lost);
        s_d.err  = set_err  || (s_q.err  && !clr_err);

        if (rx_reset) begin
            s_d    = CTL_RESET;
            wr_en  = 1'b0;
            commit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CTL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_lost = s_q.lost;
    assign rx_err  = s_q.err;

    // R10: a set flag persists until its clear bit or the receive reset.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err && !clr_err && !rx_reset |=> rx_err);

    // R6: the lost flag is sticky as well.
    p_lost_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lost && !clr_lost && !rx_reset |=> rx_lost);

    // R5: a non-zero record is only handed over when broken frames are kept.
    p_flag_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit && commit_flag != '0 |-> cfg_keep_broken);

    // R1: writes stay inside a page.
    p_wr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_addr) < DEPTH);

endmodule

// File: rtl/frame_rx_pages.sv
module frame_rx_pages #(
    parameter int NPAGE  = 2,
    parameter int DEPTH  = 258,
    parameter int ADDR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] commit_flag,
    input  logic              host_rd,
    input  logic              rd_ptr_rst,
    input  logic              page_switch,
    output logic              page_free,
    output logic              rx_ready,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] page_flag
);

    localparam int PW = (NPAGE > 1) ? $clog2(NPAGE) : 1;

    typedef struct packed {
        logic [NPAGE-1:0]             full;
        logic [PW-1:0]                wp;
        logic [PW-1:0]                hp;
        logic [ADDR_W-1:0]            rd_ptr;
        logic [NPAGE-1:0][ADDR_W-1:0] flag;
    } pg_s;

    pg_s s_d, s_q;

    logic [7:0] mem_q [NPAGE][DEPTH];

    function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p);
        return (int'(p) == NPAGE - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (commit) begin
            s_d.full[s_q.wp] = 1'b1;
            s_d.flag[s_q.wp] = commit_flag;
            s_d.wp           = ring_next(s_q.wp);
        end
        if (rd_ptr_rst) begin
            s_d.rd_ptr = '0;
        end else if (host_rd) begin
            s_d.rd_ptr = s_q.rd_ptr + 1'b1;
        end
        if (page_switch && s_q.full[s_q.hp]) begin
            s_d.full[s_q.hp] = 1'b0;
            s_d.hp           = ring_next(s_q.hp);
            s_d.rd_ptr       = '0;
        end
        if (rx_reset) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar g = 0; g < NPAGE; g++) begin : g_page
            always_ff @(posedge clk) begin
                if (wr_en && int'(s_q.wp) == g) begin
                    mem_q[g][wr_addr] <= wr_data;
                end
            end
        end
    endgenerate

    assign page_free = !s_q.full[s_q.wp];
    assign rx_ready  = s_q.full[s_q.hp];
    assign page_flag = s_q.flag[s_q.hp];
    assign rd_data   = (int'(s_q.rd_ptr) < DEPTH) ? mem_q[s_q.hp][s_q.rd_ptr] : 8'h00;

    // R6: a frame is never committed into a page that is still occupied.
    p_commit_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> page_free);

    // R7: a presented page stays presented until the host releases it.
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && !page_switch && !rx_reset |=> rx_ready);

    // R11: the receive reset empties every page.
    p_reset_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> !rx_ready && page_free);

endmodule

// File: rtl/frame_rx_pager.sv
module frame_rx_pager #(
    parameter int MAX_LEN = 253,
    parameter int NPAGE   = 2,
    localparam int DEPTH  = MAX_LEN + 5,
    localparam int ADDR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_reset,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              bus_idle,
    input  logic              cfg_user_crc,
    input  logic              cfg_keep_broken,
    input  logic              clr_lost,
    input  logic              clr_err,
    input  logic              host_rd,
    input  logic              rd_ptr_rst,
    input  logic              page_switch,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] page_flag,
    output logic              rx_ready,
    output logic              rx_lost,
    output logic              rx_err
);

    logic              crc_en;
    logic              crc_first;
    logic [15:0]       crc_next;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              commit;
    logic [ADDR_W-1:0] commit_flag;
    logic              page_free;

    frame_rx_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (crc_en),
        .first    (crc_first),
        .din      (byte_data),
        .crc_next (crc_next)
    );

    frame_rx_ctl #(
        .MAX_LEN (MAX_LEN),
        .DEPTH   (DEPTH),
        .ADDR_W  (ADDR_W)
    ) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_reset        (rx_reset),
        .byte_vld        (byte_vld),
        .byte_data       (byte_data),
        .bus_idle        (bus_idle),
        .cfg_user_crc    (cfg_user_crc),
        .cfg_keep_broken (cfg_keep_broken),
        .clr_lost        (clr_lost),
        .clr_err         (clr_err),
        .page_free       (page_free),
        .crc_next        (crc_next),
        .crc_en          (crc_en),
        .crc_first       (crc_first),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .commit          (commit),
        .commit_flag     (commit_flag),
        .rx_lost         (rx_lost),
        .rx_err          (rx_err)
    );

    frame_rx_pages #(
        .NPAGE  (NPAGE),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_pages (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_reset    (rx_reset),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_flag (commit_flag),
        .host_rd     (host_rd),
        .rd_ptr_rst  (rd_ptr_rst),
        .page_switch (page_switch),
        .page_free   (page_free),
        .rx_ready    (rx_ready),
        .rd_data     (rd_data),
        .page_flag   (page_flag)
    );

endmodule

// File: tb/frame_rx_pager_tb.sv
module frame_rx_pager_tb;

    localparam int MAX_LEN = 12;
    localparam int DEPTH   = MAX_LEN + 5;
    localparam int AW      = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_reset = 1'b0, byte_vld = 1'b0, bus_idle = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic cfg_user_crc = 1'b0, cfg_keep_broken = 1'b0;
    logic clr_lost = 1'b0, clr_err = 1'b0;
    logic host_rd = 1'b0, rd_ptr_rst = 1'b0, page_switch = 1'b0;
    logic [7:0] rd_data;
    logic [AW-1:0] page_flag;
    logic rx_ready, rx_lost, rx_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] fb [0:31];
    int flen;

    always #10 clk = ~clk;

    frame_rx_pager #(.MAX_LEN(MAX_LEN), .NPAGE(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
        .byte_vld(byte_vld), .byte_data(byte_data), .bus_idle(bus_idle),
        .cfg_user_crc(cfg_user_crc), .cfg_keep_broken(cfg_keep_broken),
        .clr_lost(clr_lost), .clr_err(clr_err), .host_rd(host_rd),
        .rd_ptr_rst(rd_ptr_rst), .page_switch(page_switch),
        .rd_data(rd_data), .page_flag(page_flag), .rx_ready(rx_ready),
        .rx_lost(rx_lost), .rx_err(rx_err)
    );

    // Bitwise reflected CRC, data bit by data bit.
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fbit;
                fbit = c[0] ^ fb[i][b];
                c = c >> 1;
                if (fbit) c = c ^ 16'hA001;
            end
        end
        return c;
    endfunction

    task automatic build(input int seed, input int len);
        logic [15:0] c;
        fb[0] = 8'(seed);
        fb[1] = 8'(seed) ^ 8'h5A;
        fb[2] = 8'(len);
        for (int i = 0; i < len; i++) fb[3 + i] = 8'(seed * 7 + i * 13 + 1);
        c = ref_crc(len + 3);
        fb[len + 3] = c[7:0];
        fb[len + 4] = c[15:8];
        flen = len + 5;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int n, input bit idle);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1;
            byte_data = fb[i];
            @(negedge clk);
        end
        byte_vld = 1'b0;
        if (idle) begin
            bus_idle = 1'b1;
            @(negedge clk);
            bus_idle = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic read_page(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(int'(rd_data), int'(fb[i]), tag);
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
        end
    endtask

    task automatic ctl(input bit sw, input bit rp, input bit cl, input bit ce, input bit rr);
        page_switch = sw; rd_ptr_rst = rp; clr_lost = cl; clr_err = ce; rx_reset = rr;
        @(negedge clk);
        page_switch = 0; rd_ptr_rst = 0; clr_lost = 0; clr_err = 0; rx_reset = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk(rx_ready, 0, "R13 ready");
        chk(rx_lost, 0, "R13 lost");
        chk(rx_err, 0, "R13 err");
        chk(int'(page_flag), 0, "R13 flag");

        // R1 R2 R7: good frames at every length
        for (int len = 0; len <= MAX_LEN; len++) begin
            build(len + 1, len);
            send(flen, 1);
            chk(rx_ready, 1, "R1 ready");
            chk(int'(page_flag), 0, "R1 flag");
            chk(rx_err, 0, "R2 no err on good CRC");
            read_page(flen, "R1 data");
            ctl(1, 0, 0, 0, 0);
            chk(rx_ready, 0, "R7 released");
        end

        // R2 R10: damaged CRC at every length
        for (int len = 0; len <= MAX_LEN; len++) begin
            build(len + 50, len);
            fb[flen - 1] = fb[flen - 1] ^ 8'h01;
            send(flen, 1);
            chk(rx_err, 1, "R2 bad CRC err");
            chk(rx_ready, 0, "R5 bad frame dropped");
            ctl(0, 0, 0, 1, 0);
            chk(rx_err, 0, "R10 err cleared");
        end

        // R4 R5: truncation at every position, broken frames kept
        cfg_keep_broken = 1'b1;
        build(77, 6);
        for (int cut = 1; cut < flen; cut++) begin
            send(cut, 1);
            chk(rx_err, 1, "R4 truncated err");
            chk(rx_ready, 1, "R5 kept ready");
            chk(int'(page_flag), cut, "R5 record");
            read_page(cut, "R5 data");
            ctl(1, 0, 0, 1, 0);
        end
        cfg_keep_broken = 1'b0;
        send(5, 1);
        chk(rx_err, 1, "R4 truncated err keep off");
        chk(rx_ready, 0, "R4 truncated dropped");
        ctl(0, 0, 0, 1, 0);

        // R3: oversize length byte
        build(9, MAX_LEN);
        fb[2] = 8'(MAX_LEN + 1);
        cfg_keep_broken = 1'b1;
        send(8, 1);
        chk(rx_err, 1, "R3 oversize err");
        chk(rx_ready, 1, "R3 kept");
        chk(int'(page_flag), 3, "R3 record at length byte");
        read_page(3, "R3 data");
        ctl(1, 0, 0, 1, 0);
        cfg_keep_broken = 1'b0;
        send(8, 1);
        chk(rx_err, 1, "R3 oversize err keep off");
        chk(rx_ready, 0, "R3 dropped");
        ctl(0, 0, 0, 1, 0);

        // R6 R7: two pages filled, third frame lost
        build(40, 3); send(flen, 1);
        build(41, 5); send(flen, 1);
        build(42, 2); send(flen, 1);
        chk(rx_lost, 1, "R6 lost set");
        chk(rx_ready, 1, "R7 ready with two pages");
        build(40, 3);
        read_page(flen, "R6 first page kept");
        ctl(1, 0, 0, 0, 0);
        chk(rx_ready, 1, "R7 second page presented");
        build(41, 5);
        read_page(flen, "R7 second page order");
        ctl(1, 0, 0, 0, 0);
        chk(rx_ready, 0, "R6 lost frame not stored");
        chk(rx_lost, 1, "R10 lost sticky");
        ctl(0, 0, 1, 0, 0);
        chk(rx_lost, 0, "R10 lost cleared");

        // R8: rewind the read position
        build(60, 4); send(flen, 1);
        read_page(3, "R8 first pass");
        ctl(0, 1, 0, 0, 0);
        read_page(flen, "R8 after rewind");
        ctl(1, 0, 0, 0, 0);

        // R9: user CRC mode
        cfg_user_crc = 1'b1;
        build(70, 4);
        fb[flen - 2] = fb[flen - 2] ^ 8'hFF;
        send(flen, 1);
        chk(rx_err, 0, "R9 no check");
        chk(rx_ready, 1, "R9 accepted");
        chk(int'(page_flag), 0, "R9 flag");
        read_page(flen, "R9 CRC bytes as data");
        ctl(1, 0, 0, 0, 0);
        cfg_user_crc = 1'b0;

        // R12: bytes after frame end ignored until idle
        build(80, 2); send(flen, 0);
        build(81, 3); send(flen, 1);
        chk(rx_ready, 1, "R12 first frame");
        build(80, 2);
        read_page(flen, "R12 data");
        ctl(1, 0, 0, 0, 0);
        chk(rx_ready, 0, "R12 trailing bytes ignored");

        // R11: receive reset
        build(90, 3); fb[flen - 1] = ~fb[flen - 1]; send(flen, 1);
        build(91, 3); send(flen, 1);
        send(3, 0);
        ctl(0, 0, 0, 0, 1);
        chk(rx_ready, 0, "R11 pages empty");
        chk(rx_err, 0, "R11 err cleared");
        build(92, 6); send(flen, 1);
        chk(rx_ready, 1, "R11 path restarts");
        chk(int'(page_flag), 0, "R11 flag");
        read_page(flen, "R11 data");
        ctl(1, 0, 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule